// File: doc/BRIEF.md
# Interrupt Pending and Trigger Gateway

This block keeps the pending state of every interrupt source of a core-local interrupt controller. Each source has a raw input line. Software sees four byte fields per source through a byte-addressable register port: pending, enable, attribute and control. The attribute field selects how the raw line is captured. In level mode pending follows the line. In rising-edge or falling-edge mode a qualifying transition latches pending, and it stays latched until software clears it or the core acknowledges the source.

The block also holds a global configuration byte and a threshold byte, and it answers a fixed read-only info word. Its outputs feed an arbiter: per-source pending, enable, selective-vector flag and control byte, plus the configuration and threshold bytes. The arbiter does the level and priority decoding and the selection.

The register port is word-addressed for reads: `bus_rdata` is combinational from `bus_addr`, and `bus_addr[1:0]` is ignored for reads. Writes use byte lanes, where lane k is byte address word+k. Writes and acknowledges take effect at the rising clock edge.

Top module: `intr_gateway`

## Requirements
- R1: After reset, every per-source pending, enable, attribute and control byte is zero, as are the configuration and threshold bytes and the stored previous input of each source. Every output is low.
- R2: Source id has a word at 0x1000 + 4*id. Lane 0 is pending (bit 0 stored, read as 0 or 1), lane 1 is enable, lane 2 is attribute and lane 3 is control. Enable, attribute and control keep all 8 written bits, and the word reads as {control, attribute, enable, 7'b0, pending}.
- R3: The configuration byte sits in lane 0 of word 0x000. The threshold byte sits at 0x00B, which is lane 3 of word 0x008. Both are read/write and are driven on `cfg_o` and `thr_o`.
- R4: Word 0x004 always reads 0x00C00000, which is the value 6 placed at bit 21. Writes to it have no effect.
- R5: Reads of any other offset, including slots with id >= NSRC, return zero. Writes to those offsets change nothing.
- R6: When attribute bit 1 is 0 (trigger field bits [2:1] = 00 or 10, level mode), pending after each clock edge equals the raw input sampled at that edge.
- R7: When trigger field bits [2:1] = 01 (rising edge), a raw input sampled at 1 with a previous sample of 0 sets pending. The previous sample is 0 after reset. Pending stays set through later non-qualifying input activity.
- R8: When trigger field bits [2:1] = 11 (falling edge), a raw input sampled at 0 with a previous sample of 1 sets pending. A 0-to-1 transition does not set it.
- R9: In edge mode, a write to lane 0 of the source's word loads pending from `bus_wdata[0]`. In level mode the write is ignored.
- R10: An acknowledge (`ack_valid` with `ack_id` = id) clears pending of an edge-mode source.
- R11: When several events hit one edge-mode source in the same cycle, a qualifying edge wins over a software write, and a software write wins over an acknowledge.
- R12: `en_o[id]` is enable bit 0, `shv_o[id]` is attribute bit 0 (selective vector), and `ctl_o[8*id +: 8]` is the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_raw | input | NSRC | Raw interrupt lines, one per source |
| bus_addr | input | AW | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_id | input | IDW | Acknowledged source id |
| pend_o | output | NSRC | Pending per source |
| en_o | output | NSRC | Enable per source |
| shv_o | output | NSRC | Selective-vector flag per source |
| ctl_o | output | 8*NSRC | Control byte per source |
| cfg_o | output | 8 | Configuration byte |
| thr_o | output | 8 | Threshold byte |

## Verification
The hardest case to reach from the ports is a single edge-mode source that gets a qualifying edge, a software write to its pending lane and an acknowledge all in the same cycle. The stimulus must first switch the mode, then line up the raw line, the bus write and the acknowledge on one edge. Directed steps build exactly that collision for each priority pair. A long run then follows with sparse random toggling of the raw lines, random writes that sometimes change the trigger mode mid-stream, and random acknowledges. A bench model predicts every output and every read-back word cycle by cycle.

// File: rtl/intr_gateway_pkg.sv
package intr_gateway_pkg;

  localparam int CFG_OFF   = 'h000;
  localparam int INFO_OFF  = 'h004;
  localparam int THR_WORD  = 'h008;
  localparam int SLOT_BASE = 'h1000;
  localparam int CTL_BITS  = 6;
  localparam int INFO_POS  = 21;

  typedef enum logic [1:0] {
    TRIG_LEVEL   = 2'b00,
    TRIG_RISE    = 2'b01,
    TRIG_LEVEL_B = 2'b10,
    TRIG_FALL    = 2'b11
  } trig_e;

  typedef struct packed {
    logic cfg;
    logic info;
    logic thr;
    logic slot;
  } hit_t;

  function automatic trig_e trig_of(input logic [7:0] attr);
    return trig_e'(attr[2:1]);
  endfunction

  function automatic logic is_edge_mode(input logic [7:0] attr);
    return attr[1];
  endfunction

  function automatic logic edge_hit(input logic [7:0] attr, input logic now, input logic prev);
    case (trig_of(attr))
      TRIG_RISE: return now & ~prev;
      TRIG_FALL: return ~now & prev;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] info_word();
    return 32'(CTL_BITS) << INFO_POS;
  endfunction

  function automatic logic [31:0] slot_word(input logic pend, input logic [7:0] en,
                                            input logic [7:0] attr, input logic [7:0] ctl);
    return {ctl, attr, en, 7'b0, pend};
  endfunction

endpackage

// File: rtl/intr_gateway_decode.sv
module intr_gateway_decode
  import intr_gateway_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NSRC = 32,
  parameter int IDW  = 5
) (
  input  logic [AW-1:0]  addr,
  output hit_t           hit,
  output logic [IDW-1:0] idx
);
  localparam logic [AW-1:0] BASE = AW'(SLOT_BASE);

  logic [AW-1:0] off;
  logic [AW-3:0] word;

  always_comb begin
    off      = addr - BASE;
    word     = addr[AW-1:2];
    hit.cfg  = (word == (AW-2)'(CFG_OFF >> 2));
    hit.info = (word == (AW-2)'(INFO_OFF >> 2));
    hit.thr  = (word == (AW-2)'(THR_WORD >> 2));
    hit.slot = (addr >= BASE) && (int'(off >> 2) < NSRC);
    idx      = off[IDW+1:2];
  end
endmodule

// File: rtl/intr_gateway_cell.sv
module intr_gateway_cell
  import intr_gateway_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_i,
  input  logic       wr_i,
  input  logic [3:0] be_i,
  input  logic       wpend_i,
  input  logic [7:0] wen_i,
  input  logic [7:0] wattr_i,
  input  logic [7:0] wctl_i,
  input  logic       ack_i,
  output logic       pend_o,
  output logic [7:0] en_o,
  output logic [7:0] attr_o,
  output logic [7:0] ctl_o
);
  logic       prev_q, pend_q, pend_d;
  logic [7:0] en_q, attr_q, ctl_q;
  logic       edge_mode, edge_set, sw_wr;

  assign edge_mode = is_edge_mode(attr_q);
  assign edge_set  = edge_mode & edge_hit(attr_q, raw_i, prev_q);
  assign sw_wr     = wr_i & be_i[0];

  always_comb begin
    if (!edge_mode)    pend_d = raw_i;
    else if (edge_set) pend_d = 1'b1;
    else if (sw_wr)    pend_d = wpend_i;
    else if (ack_i)    pend_d = 1'b0;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= '0;
      attr_q <= '0;
      ctl_q  <= '0;
    end else begin
      prev_q <= raw_i;
      pend_q <= pend_d;
      if (wr_i && be_i[1]) en_q   <= wen_i;
      if (wr_i && be_i[2]) attr_q <= wattr_i;
      if (wr_i && be_i[3]) ctl_q  <= wctl_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign attr_o = attr_q;
  assign ctl_o  = ctl_q;

  assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !attr_q[1] |=> pend_q == $past(raw_i));
  assert_rise_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_set && !attr_q[2]) |=> pend_q);
  assert_fall_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_set && attr_q[2]) |=> pend_q);
  assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !edge_set && !sw_wr && !ack_i) |=> $stable(pend_q));
  assert_sw_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !edge_set && sw_wr) |=> pend_q == $past(wpend_i));
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !edge_set && !sw_wr && ack_i) |=> !pend_q);
endmodule

// File: rtl/intr_gateway.sv
module intr_gateway
  import intr_gateway_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 16,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_raw,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ack_valid,
  input  logic [IDW-1:0]    ack_id,
  output logic [NSRC-1:0]   pend_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   shv_o,
  output logic [8*NSRC-1:0] ctl_o,
  output logic [7:0]        cfg_o,
  output logic [7:0]        thr_o
);
  hit_t           hit;
  logic [IDW-1:0] idx;
  logic [7:0]     cfg_q, thr_q;
  logic [7:0]     en_b   [NSRC];
  logic [7:0]     attr_b [NSRC];
  logic [7:0]     ctl_b  [NSRC];
  logic           slot_wr;

  intr_gateway_decode #(.AW(AW), .NSRC(NSRC), .IDW(IDW)) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  assign slot_wr = bus_wr & hit.slot;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    intr_gateway_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (irq_raw[i]),
      .wr_i    (slot_wr && (idx == IDW'(i))),
      .be_i    (bus_be),
      .wpend_i (bus_wdata[0]),
      .wen_i   (bus_wdata[15:8]),
      .wattr_i (bus_wdata[23:16]),
      .wctl_i  (bus_wdata[31:24]),
      .ack_i   (ack_valid && (ack_id == IDW'(i))),
      .pend_o  (pend_o[i]),
      .en_o    (en_b[i]),
      .attr_o  (attr_b[i]),
      .ctl_o   (ctl_b[i])
    );
    assign en_o[i]        = en_b[i][0];
    assign shv_o[i]       = attr_b[i][0];
    assign ctl_o[8*i +: 8] = ctl_b[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      thr_q <= '0;
    end else if (bus_wr) begin
      if (hit.cfg && bus_be[0]) cfg_q <= bus_wdata[7:0];
      if (hit.thr && bus_be[3]) thr_q <= bus_wdata[31:24];
    end
  end

  assign cfg_o = cfg_q;
  assign thr_o = thr_q;

  always_comb begin
    bus_rdata = '0;
    if (hit.slot)      bus_rdata = slot_word(pend_o[idx], en_b[idx], attr_b[idx], ctl_b[idx]);
    else if (hit.cfg)  bus_rdata = {24'b0, cfg_q};
    else if (hit.info) bus_rdata = info_word();
    else if (hit.thr)  bus_rdata = {thr_q, 24'b0};
  end

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> bus_rdata == 32'b0);
  assert_info_static_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit.info |-> bus_rdata == 32'h00C0_0000);
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit.cfg && bus_be[0]) |=> $stable(cfg_o));
endmodule

// File: tb/intr_gateway_test.sv
module intr_gateway_test;
  localparam int N  = 32;
  localparam int AW = 16;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]   irq_raw = '0;
  logic [AW-1:0]  bus_addr = '0;
  logic           bus_wr = 1'b0;
  logic [3:0]     bus_be = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           ack_valid = 1'b0;
  logic [IW-1:0]  ack_id = '0;
  logic [N-1:0]   pend_o, en_o, shv_o;
  logic [8*N-1:0] ctl_o;
  logic [7:0]     cfg_o, thr_o;

  intr_gateway #(.NSRC(N), .AW(AW)) uut (.*);

  logic       m_pend [N];
  logic       m_prev [N];
  logic [7:0] m_en [N], m_attr [N], m_ctl [N];
  logic [7:0] m_cfg, m_thr;
  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    int w = int'(a) & ~3;
    if (w == 0) return {24'h0, m_cfg};
    if (w == 4) return 32'h00C0_0000;
    if (w == 8) return {m_thr, 24'h0};
    if (w >= 'h1000 && (w - 'h1000) / 4 < N) begin
      int id = (w - 'h1000) / 4;
      return {m_ctl[id], m_attr[id], m_en[id], 7'h0, m_pend[id]};
    end
    return 32'h0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      m_pend[i] = 0; m_prev[i] = 0; m_en[i] = 0; m_attr[i] = 0; m_ctl[i] = 0;
    end
    m_cfg = 0; m_thr = 0;
  endtask

  task automatic m_cycle(input logic wr, input logic [AW-1:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input logic ak, input logic [IW-1:0] aid);
    int w = int'(a) & ~3;
    int sid = ((w >= 'h1000) && ((w - 'h1000) / 4 < N)) ? (w - 'h1000) / 4 : -1;
    for (int i = 0; i < N; i++) begin
      logic e;
      logic mine = wr && (sid == i);
      case (m_attr[i][2:1])
        2'b01: e = irq_raw[i] && !m_prev[i];
        2'b11: e = !irq_raw[i] && m_prev[i];
        default: e = 0;
      endcase
      if (m_attr[i][1] == 1'b0) m_pend[i] = irq_raw[i];
      else if (e) m_pend[i] = 1;
      else if (mine && be[0]) m_pend[i] = wd[0];
      else if (ak && aid == IW'(i)) m_pend[i] = 0;
      m_prev[i] = irq_raw[i];
      if (mine && be[1]) m_en[i] = wd[15:8];
      if (mine && be[2]) m_attr[i] = wd[23:16];
      if (mine && be[3]) m_ctl[i] = wd[31:24];
    end
    if (wr && w == 0 && be[0]) m_cfg = wd[7:0];
    if (wr && w == 8 && be[3]) m_thr = wd[31:24];
  endtask

  task automatic check_outs(input string tag);
    logic [N-1:0] ep, ee, es;
    logic [8*N-1:0] ec;
    for (int i = 0; i < N; i++) begin
      ep[i] = m_pend[i]; ee[i] = m_en[i][0]; es[i] = m_attr[i][0]; ec[8*i +: 8] = m_ctl[i];
    end
    chk({tag, " pend R6 R7 R8"}, 256'(pend_o), 256'(ep));
    chk({tag, " en/shv R12"}, 256'({en_o, shv_o, cfg_o, thr_o}), 256'({ee, es, m_cfg, m_thr}));
    chk({tag, " ctl R12"}, 256'(ctl_o), 256'(ec));
  endtask

  task automatic step(input logic wr, input logic [AW-1:0] a, input logic [3:0] be,
                      input logic [31:0] wd, input logic ak, input logic [IW-1:0] aid);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd; ack_valid = ak; ack_id = aid;
    m_cycle(wr, a, be, wd, ak, aid);
    @(posedge clk);
    #1;
    bus_wr = 0; ack_valid = 0;
  endtask

  task automatic tick();
    step(0, 16'h0, 4'h0, 32'h0, 0, '0);
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    bus_addr = a;
    #1;
    chk(tag, 256'(bus_rdata), 256'(m_read(a)));
  endtask

  function automatic logic [AW-1:0] slot(input int id);
    return AW'('h1000 + 4 * id);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 reset pend", 256'(pend_o), 256'(0));
    chk("R1 reset other", 256'({en_o, shv_o, cfg_o, thr_o}), 256'(0));
    chk("R1 reset ctl", 256'(ctl_o), 256'(0));
    rd("R1 slot3 read zero", slot(3));

    // R4 info word
    rd("R4 info read", 16'h0004);
    chk("R4 info const", 256'(bus_rdata), 256'(32'h00C0_0000));
    step(1, 16'h0004, 4'hF, 32'hFFFF_FFFF, 0, '0);
    rd("R4 info after write", 16'h0006);
    chk("R4 info unchanged", 256'(bus_rdata), 256'(32'h00C0_0000));

    // R5 unmapped
    step(1, 16'h000C, 4'hF, 32'hFFFF_FFFF, 0, '0);
    step(1, slot(N), 4'hF, 32'hFFFF_FFFF, 0, '0);
    check_outs("R5 unmapped write");
    rd("R5 unmapped read 0x00C", 16'h000C);
    rd("R5 read past slots", slot(N));
    chk("R5 past slots zero", 256'(bus_rdata), 256'(0));

    // R3 globals
    step(1, 16'h0000, 4'h1, 32'h1122_335A, 0, '0);
    step(1, 16'h0008, 4'h8, 32'hC344_5566, 0, '0);
    chk("R3 cfg_o", 256'(cfg_o), 256'(8'h5A));
    chk("R3 thr_o", 256'(thr_o), 256'(8'hC3));
    rd("R3 thr read", 16'h000B);
    chk("R3 thr word", 256'(bus_rdata), 256'(32'hC300_0000));

    // R2 slot layout, attr bits [2:1]=10 is level
    step(1, slot(5), 4'hE, 32'hA73C_FF01, 0, '0);
    rd("R2 slot5 read", slot(5));
    chk("R2 slot5 word", 256'(bus_rdata), 256'(32'hA73C_FF00));
    chk("R12 ctl5", 256'(ctl_o[47:40]), 256'(8'hA7));

    // R6 level on source 2
    irq_raw[2] = 1; tick();
    chk("R6 level high", 256'(pend_o[2]), 256'(1));
    irq_raw[2] = 0; tick();
    chk("R6 level low", 256'(pend_o[2]), 256'(0));
    step(1, slot(2), 4'h1, 32'h1, 0, '0);
    chk("R9 level write ignored", 256'(pend_o[2]), 256'(0));

    // R7 rising on source 4
    step(1, slot(4), 4'h4, 32'h0002_0000, 0, '0);
    irq_raw[4] = 1; tick();
    chk("R7 rise sets", 256'(pend_o[4]), 256'(1));
    irq_raw[4] = 0; tick(); tick();
    chk("R7 stays set", 256'(pend_o[4]), 256'(1));
    step(0, 16'h0, 4'h0, 32'h0, 1, IW'(4));
    chk("R10 ack clears", 256'(pend_o[4]), 256'(0));

    // R9 software set/clear in edge mode
    step(1, slot(4), 4'h1, 32'h1, 0, '0);
    chk("R9 sw set", 256'(pend_o[4]), 256'(1));
    step(1, slot(4), 4'h1, 32'h0, 0, '0);
    chk("R9 sw clear", 256'(pend_o[4]), 256'(0));

    // R11 priorities on source 4
    irq_raw[4] = 1;
    step(1, slot(4), 4'h1, 32'h0, 1, IW'(4));
    chk("R11 edge beats write and ack", 256'(pend_o[4]), 256'(1));
    step(1, slot(4), 4'h1, 32'h1, 1, IW'(4));
    chk("R11 write beats ack", 256'(pend_o[4]), 256'(1));
    irq_raw[4] = 0;

    // R8 falling on source 6, R12 shv on source 7
    step(1, slot(6), 4'h4, 32'h0006_0000, 0, '0);
    irq_raw[6] = 1; tick();
    chk("R8 rising ignored", 256'(pend_o[6]), 256'(0));
    irq_raw[6] = 0; tick();
    chk("R8 fall sets", 256'(pend_o[6]), 256'(1));
    step(1, slot(7), 4'h6, 32'h0003_0100, 0, '0);
    chk("R12 shv and en", 256'({shv_o[7], en_o[7]}), 256'(2'b11));
    check_outs("directed end");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic wr, ak;
      logic [AW-1:0] a;
      int sel;
      irq_raw = irq_raw ^ N'($urandom & $urandom & $urandom);
      wr = ($urandom % 10) < 4;
      sel = $urandom % 10;
      case (sel)
        0: a = 16'h0000;
        1: a = 16'h0004;
        2: a = 16'h0008;
        3: a = ($urandom % 2) ? 16'h000C : slot(N + int'($urandom % 4));
        default: a = slot(int'($urandom % N));
      endcase
      ak = ($urandom % 10) < 3;
      step(wr, a, 4'($urandom), $urandom, ak, IW'($urandom));
      check_outs("random");
      rd("random read R2 R3 R5", slot(int'($urandom % (N + 2))));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule